// File: doc/BRIEF.md
# Asynchronous SRAM interface controller

This block sits between a synchronous host and an 8192-word by 8-bit asynchronous static RAM. The host issues single-cycle requests, either a read or a write, and the block turns each one into a strobe sequence on the RAM pins. That sequence covers two chip selects of opposite polarity, an active-low read (output) enable, an active-low write strobe, a 13-bit address and a split data bus: a driven value, its drive enable and the returned value. Reads end with a one-cycle valid strobe carrying the data. Writes end with a one-cycle completion strobe.

All RAM timing limits are parameters given in nanoseconds, together with the clock period. At elaboration the block converts each limit to a whole number of clock cycles, rounding up. It then merges the limits that apply to the same interval and keeps the largest. Writes are controlled by the write strobe. The data bus is driven only while that strobe is low. A write that directly follows a read waits extra cycles with the read enable high, so that the RAM has released the bus before the block drives it.

Top module: `asram_ctrl`

## Requirements
- R1: While reset is asserted, and right after it, mem_en_n=1, mem_en=0, mem_rden_n=1, mem_wren_n=1, mem_dq_oe=0, busy=0, rvalid=0 and wdone=0. Reset is asynchronous and active low, and it aborts any operation in progress.
- R2: mem_rden_n and mem_wren_n are never low in the same cycle. mem_dq_oe is 1 only while mem_wren_n=0, mem_en_n=0 and mem_en=1.
- R3: In a write, mem_wren_n stays low for exactly NP = max(ceil(T_PWE/T), ceil(T_AW/T), ceil(T_SD/T)) consecutive cycles, which is 2 at the defaults. mem_dq_o holds the write data for that whole time.
- R4: The address is captured at the edge that accepts a request. mem_addr then stays constant for as long as the selects remain asserted.
- R5: After mem_wren_n rises, the selects stay asserted with the bus released for NH = max(1, ceil(T_WC/T) - NP) cycles, which is 1 at the defaults. wdone then pulses, NP+NH+1 sampled cycles after the request cycle (4 at the defaults).
- R6: A read holds mem_en_n=0, mem_en=1, mem_rden_n=0 and mem_wren_n=1 for NR = max(ceil(T_AA/T), ceil(T_DOE/T)) cycles, which is 2 at the defaults. It samples mem_dq_i at the end of that window. rvalid pulses NR+1 cycles after the request cycle, and rdata keeps that value until the next read completes.
- R7: A write accepted while the previous completed operation was a read inserts NT = max(1, ceil(T_HZOE/T)) extra cycles with all strobes inactive before mem_wren_n falls. A write after a write, or after reset, inserts none.
- R8: rvalid and wdone are each one cycle wide and never high together. busy is high from the cycle after acceptance until the cycle in which the completion strobe is high, and it is low in that cycle.
- R9: A request presented while busy=1 is ignored. It starts no operation, does not change mem_addr, and leaves the memory contents untouched.
- R10: Each limit in nanoseconds becomes the smallest whole cycle count whose duration is at least that limit, and never less than one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Request strobe, taken only when idle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Request address |
| req_wdata | input | DATA_W | Write data |
| busy | output | 1 | Operation in progress |
| rdata | output | DATA_W | Last read data |
| rvalid | output | 1 | One-cycle read completion |
| wdone | output | 1 | One-cycle write completion |
| mem_addr | output | ADDR_W | RAM address |
| mem_en_n | output | 1 | RAM select, active low |
| mem_en | output | 1 | RAM select, active high |
| mem_rden_n | output | 1 | RAM output enable, active low |
| mem_wren_n | output | 1 | RAM write strobe, active low |
| mem_dq_o | output | DATA_W | Value driven onto the RAM data bus |
| mem_dq_oe | output | 1 | Drive enable for mem_dq_o |
| mem_dq_i | input | DATA_W | Value read from the RAM data bus |

## Verification
A wrong sequencer state shows at the pins within one clock. Such a state produces a read enable overlapping a write strobe, a write strobe that is too short or too long, or bus drive outside the write pulse. A timing model on the RAM side flags each of these at the edge where it happens. A wrong cycle count or a missing turnaround changes the latency of rvalid or wdone by whole cycles. It also makes the model return corrupted data, so the error appears at the first completion that follows. A request leaking through while busy shows up as an extra completion strobe or as a stray written byte on read-back.

// File: rtl/asram_ctrl_pkg.sv
package asram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_TURN   = 3'd1,
    ST_WPULSE = 3'd2,
    ST_WHOLD  = 3'd3,
    ST_READ   = 3'd4
  } seq_state_e;

  typedef struct packed {
    logic sel;
    logic rd;
    logic wr;
    logic drive;
  } strobe_t;

  // Smallest cycle count covering ns, at least one cycle.
  function automatic int unsigned ns_to_cycles(input int unsigned ns,
                                               input int unsigned period);
    int unsigned c;
    c = (ns + period - 1) / period;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // Hold cycles after the write strobe so the full write cycle is met.
  function automatic int unsigned hold_cycles(input int unsigned wc,
                                              input int unsigned pulse);
    return (wc > pulse) ? (wc - pulse) : 1;
  endfunction

  // Pin strobes that belong to each sequencer state.
  function automatic strobe_t strobes_for(input seq_state_e s);
    strobe_t r;
    r = '0;
    case (s)
      ST_WPULSE: begin r.sel = 1'b1; r.wr = 1'b1; r.drive = 1'b1; end
      ST_WHOLD:  begin r.sel = 1'b1; end
      ST_READ:   begin r.sel = 1'b1; r.rd = 1'b1; end
      default:   r = '0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/asram_ctrl_timer.sv
module asram_ctrl_timer #(
  parameter int unsigned CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             last
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q > CNT_W'(1)) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assign last = (cnt_q == CNT_W'(1));

  // R10: a loaded count runs down by one per cycle until its final cycle
  a_r10_countdown: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt_q > CNT_W'(1)) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

endmodule

// File: rtl/asram_ctrl_seq.sv
module asram_ctrl_seq
  import asram_ctrl_pkg::*;
#(
  parameter int unsigned N_RD   = 2,
  parameter int unsigned N_PWE  = 2,
  parameter int unsigned N_WH   = 1,
  parameter int unsigned N_TURN = 1,
  parameter int unsigned CNT_W  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic             req_we,
  input  logic             tmr_last,
  output seq_state_e       state_nxt,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val,
  output logic             accept,
  output logic             rd_done,
  output logic             wr_done,
  output logic             busy
);

  seq_state_e state_q;
  logic       last_rd_q;

  assign accept  = (state_q == ST_IDLE) && req;
  assign rd_done = (state_q == ST_READ) && tmr_last;
  assign wr_done = (state_q == ST_WHOLD) && tmr_last;
  assign busy    = (state_q != ST_IDLE);

  always_comb begin
    state_nxt = state_q;
    case (state_q)
      ST_IDLE: begin
        if (req) begin
          if (!req_we)        state_nxt = ST_READ;
          else if (last_rd_q) state_nxt = ST_TURN;
          else                state_nxt = ST_WPULSE;
        end
      end
      ST_TURN:   if (tmr_last) state_nxt = ST_WPULSE;
      ST_WPULSE: if (tmr_last) state_nxt = ST_WHOLD;
      ST_WHOLD:  if (tmr_last) state_nxt = ST_IDLE;
      ST_READ:   if (tmr_last) state_nxt = ST_IDLE;
      default:   state_nxt = ST_IDLE;
    endcase
  end

  always_comb begin
    case (state_nxt)
      ST_TURN:   tmr_val = CNT_W'(N_TURN);
      ST_WPULSE: tmr_val = CNT_W'(N_PWE);
      ST_WHOLD:  tmr_val = CNT_W'(N_WH);
      ST_READ:   tmr_val = CNT_W'(N_RD);
      default:   tmr_val = '0;
    endcase
  end

  assign tmr_load = (state_nxt != state_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      last_rd_q <= 1'b0;
    end else begin
      state_q <= state_nxt;
      if (rd_done)                  last_rd_q <= 1'b1;
      else if (state_nxt == ST_WPULSE) last_rd_q <= 1'b0;
    end
  end

  // R9: an operation in flight is never replaced by a new acceptance
  a_r9_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !rd_done && !wr_done) |=> busy);

endmodule

// File: rtl/asram_ctrl_pins.sv
module asram_ctrl_pins
  import asram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W = 13,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned N_RD   = 2,
  parameter int unsigned N_PWE  = 2,
  parameter int unsigned N_TURN = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  seq_state_e        state_nxt,
  input  logic              accept,
  input  logic              rd_done,
  input  logic              wr_done,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic [DATA_W-1:0] mem_dq_i,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_en_n,
  output logic              mem_en,
  output logic              mem_rden_n,
  output logic              mem_wren_n,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid,
  output logic              wdone
);

  strobe_t stb_nxt;
  assign stb_nxt = strobes_for(state_nxt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_addr   <= '0;
      mem_dq_o   <= '0;
      mem_en_n   <= 1'b1;
      mem_en     <= 1'b0;
      mem_rden_n <= 1'b1;
      mem_wren_n <= 1'b1;
      mem_dq_oe  <= 1'b0;
      rdata      <= '0;
      rvalid     <= 1'b0;
      wdone      <= 1'b0;
    end else begin
      if (accept) begin
        mem_addr <= host_addr;
        mem_dq_o <= host_wdata;
      end
      mem_en_n   <= !stb_nxt.sel;
      mem_en     <= stb_nxt.sel;
      mem_rden_n <= !stb_nxt.rd;
      mem_wren_n <= !stb_nxt.wr;
      mem_dq_oe  <= stb_nxt.drive;
      rvalid     <= rd_done;
      wdone      <= wr_done;
      if (rd_done) rdata <= mem_dq_i;
    end
  end

  // Run-length observers of the pin strobes, used by the checks below.
  logic [7:0] wr_low_run, rd_low_run, rd_high_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_low_run  <= '0;
      rd_low_run  <= '0;
      rd_high_run <= '0;
    end else begin
      wr_low_run  <= mem_wren_n ? 8'd0 : wr_low_run + 8'd1;
      rd_low_run  <= mem_rden_n ? 8'd0 : rd_low_run + 8'd1;
      rd_high_run <= !mem_rden_n ? 8'd0 :
                     (rd_high_run == 8'hFF) ? rd_high_run : rd_high_run + 8'd1;
    end
  end

  a_r2_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_rden_n && !mem_wren_n));

  a_r2_drive_in_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> (!mem_wren_n && !mem_en_n && mem_en));

  a_r3_pulse_len: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_wren_n) |-> (wr_low_run == 8'(N_PWE)));

  a_r3_data_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_wren_n && $past(!mem_wren_n)) |-> $stable(mem_dq_o));

  a_r4_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_en_n && $past(!mem_en_n)) |-> $stable(mem_addr));

  a_r5_hold_after_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_wren_n) |-> (!mem_en_n && mem_en && !mem_dq_oe));

  a_r6_read_len: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_rden_n) |-> (rd_low_run == 8'(N_RD)));

  a_r6_rvalid_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid |-> ($past(!mem_rden_n) && mem_rden_n));

  a_r7_turn_gap: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_wren_n) |-> (rd_high_run >= 8'(N_TURN + 1)));

  a_r8_rvalid_single: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid |=> !rvalid);

  a_r8_wdone_single: assert property (@(posedge clk) disable iff (!rst_n)
    wdone |=> !wdone);

  a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(rvalid && wdone));

endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
  import asram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W    = 13,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned CLK_NS    = 10,
  parameter int unsigned T_AA_NS   = 20,
  parameter int unsigned T_DOE_NS  = 10,
  parameter int unsigned T_PWE_NS  = 15,
  parameter int unsigned T_AW_NS   = 15,
  parameter int unsigned T_SD_NS   = 10,
  parameter int unsigned T_WC_NS   = 20,
  parameter int unsigned T_HZOE_NS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              busy,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid,
  output logic              wdone,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_en_n,
  output logic              mem_en,
  output logic              mem_rden_n,
  output logic              mem_wren_n,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_i
);

  localparam int unsigned N_RD   = max2(ns_to_cycles(T_AA_NS, CLK_NS),
                                        ns_to_cycles(T_DOE_NS, CLK_NS));
  localparam int unsigned N_PWE  = max2(max2(ns_to_cycles(T_PWE_NS, CLK_NS),
                                             ns_to_cycles(T_AW_NS, CLK_NS)),
                                        ns_to_cycles(T_SD_NS, CLK_NS));
  localparam int unsigned N_WH   = hold_cycles(ns_to_cycles(T_WC_NS, CLK_NS), N_PWE);
  localparam int unsigned N_TURN = ns_to_cycles(T_HZOE_NS, CLK_NS);
  localparam int unsigned N_MAX  = max2(max2(N_RD, N_PWE), max2(N_WH, N_TURN));
  localparam int unsigned CNT_W  = $clog2(N_MAX + 1);

  seq_state_e       state_nxt;
  logic             tmr_load, tmr_last;
  logic [CNT_W-1:0] tmr_val;
  logic             accept, rd_done, wr_done;

  asram_ctrl_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .last     (tmr_last)
  );

  asram_ctrl_seq #(
    .N_RD(N_RD), .N_PWE(N_PWE), .N_WH(N_WH), .N_TURN(N_TURN), .CNT_W(CNT_W)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (req),
    .req_we    (req_we),
    .tmr_last  (tmr_last),
    .state_nxt (state_nxt),
    .tmr_load  (tmr_load),
    .tmr_val   (tmr_val),
    .accept    (accept),
    .rd_done   (rd_done),
    .wr_done   (wr_done),
    .busy      (busy)
  );

  asram_ctrl_pins #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .N_RD(N_RD), .N_PWE(N_PWE), .N_TURN(N_TURN)
  ) u_pins (
    .clk        (clk),
    .rst_n      (rst_n),
    .state_nxt  (state_nxt),
    .accept     (accept),
    .rd_done    (rd_done),
    .wr_done    (wr_done),
    .host_addr  (req_addr),
    .host_wdata (req_wdata),
    .mem_dq_i   (mem_dq_i),
    .mem_addr   (mem_addr),
    .mem_en_n   (mem_en_n),
    .mem_en     (mem_en),
    .mem_rden_n (mem_rden_n),
    .mem_wren_n (mem_wren_n),
    .mem_dq_o   (mem_dq_o),
    .mem_dq_oe  (mem_dq_oe),
    .rdata      (rdata),
    .rvalid     (rvalid),
    .wdone      (wdone)
  );

  a_r9_busy_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(mem_addr));

  a_r8_busy_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rvalid || wdone) |-> !busy);

endmodule

// File: tb/asram_ctrl_tb.sv
module asram_ctrl_tb;

  localparam int CLK_NS  = 10;
  localparam int T_AA    = 20;
  localparam int T_DOE   = 10;
  localparam int T_PWE   = 15;
  localparam int T_AW    = 15;
  localparam int T_SD    = 10;
  localparam int T_WC    = 20;
  localparam int T_HZOE  = 8;

  typedef struct packed {
    logic        wr;
    logic [12:0] addr;
    logic [7:0]  data;
  } vec_t;

  localparam int NVEC = 13;
  localparam vec_t VECS [NVEC] = '{
    '{1'b1, 13'h0000, 8'h3C},
    '{1'b1, 13'h1FFF, 8'hC3},
    '{1'b0, 13'h0000, 8'h3C},
    '{1'b1, 13'h0AAA, 8'h5A},
    '{1'b0, 13'h1FFF, 8'hC3},
    '{1'b0, 13'h0AAA, 8'h5A},
    '{1'b1, 13'h1555, 8'h81},
    '{1'b1, 13'h0000, 8'h7E},
    '{1'b0, 13'h1555, 8'h81},
    '{1'b0, 13'h0000, 8'h7E},
    '{1'b0, 13'h0123, 8'h00},
    '{1'b1, 13'h1FFF, 8'h00},
    '{1'b0, 13'h1FFF, 8'h00}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, req_we = 1'b0;
  logic [12:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        busy, rvalid, wdone;
  logic [7:0]  rdata;
  logic [12:0] mem_addr;
  logic        mem_en_n, mem_en, mem_rden_n, mem_wren_n, mem_dq_oe;
  logic [7:0]  mem_dq_o, mem_dq_i;

  int n_chk = 0, n_fail = 0, n_cyc = 0;
  int n_rvalid = 0, n_wdone = 0;

  always #(CLK_NS/2) clk = ~clk;

  asram_ctrl #(
    .CLK_NS(CLK_NS), .T_AA_NS(T_AA), .T_DOE_NS(T_DOE), .T_PWE_NS(T_PWE),
    .T_AW_NS(T_AW), .T_SD_NS(T_SD), .T_WC_NS(T_WC), .T_HZOE_NS(T_HZOE)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .req(req), .req_we(req_we), .req_addr(req_addr),
    .req_wdata(req_wdata), .busy(busy), .rdata(rdata), .rvalid(rvalid),
    .wdone(wdone), .mem_addr(mem_addr), .mem_en_n(mem_en_n), .mem_en(mem_en),
    .mem_rden_n(mem_rden_n), .mem_wren_n(mem_wren_n), .mem_dq_o(mem_dq_o),
    .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
  );

  // Cycle count by stepping whole periods until the limit is covered (R10).
  function automatic int cyc_for(input int ns);
    int c = 0;
    while (c * CLK_NS < ns) c++;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  int exp_rd, exp_pwe, exp_wh, exp_turn;

  task automatic chk(input string rq, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  // ---------------- RAM timing model ----------------
  logic [7:0]  mem_model [int unsigned];
  int          wlow = 0, rrun = 0;
  logic [12:0] w_addr = '0, r_addr = '0;
  logic [7:0]  w_data = '0, look = '0;
  logic        w_bad = 1'b0;
  logic        rd_cond, rd_ok;

  function automatic logic [7:0] peek(input logic [12:0] a);
    return mem_model.exists(int'(a)) ? mem_model[int'(a)] : 8'h00;
  endfunction

  assign rd_cond = !mem_en_n && mem_en && !mem_rden_n && mem_wren_n;
  assign rd_ok   = rd_cond && (rrun >= 1) && (mem_addr == r_addr) &&
                   ((rrun + 1) * CLK_NS >= T_AA) && ((rrun + 1) * CLK_NS >= T_DOE);
  assign mem_dq_i = rd_ok ? look : ~look;

  always @(posedge clk) begin
    look <= peek(mem_addr);
    if (rd_cond) begin
      rrun   <= (rrun == 0 || mem_addr == r_addr) ? rrun + 1 : 1;
      r_addr <= mem_addr;
    end else begin
      rrun <= 0;
    end
    if (mem_dq_oe && !mem_rden_n) begin
      n_chk++; n_fail++;
      $display("FAIL R2 bus contention actual=1 expected=0");
    end
    if (!mem_wren_n && !mem_en_n && mem_en) begin
      wlow <= wlow + 1;
      if (wlow == 0) begin
        w_addr <= mem_addr; w_data <= mem_dq_o; w_bad <= !mem_dq_oe;
      end else if (mem_addr != w_addr || mem_dq_o != w_data || !mem_dq_oe) begin
        w_bad <= 1'b1;
      end
    end else if (wlow != 0) begin
      mem_model[int'(w_addr)] = w_data;
      n_chk++;
      if (wlow * CLK_NS < imax(T_PWE, imax(T_AW, T_SD)) || w_bad || mem_addr != w_addr) begin
        n_fail++;
        $display("FAIL R3 write pulse cycles=%0d bad=%0d actual_addr=%0h expected_addr=%0h",
                 wlow, w_bad, mem_addr, w_addr);
      end
      wlow <= 0;
    end
  end

  // Completion pulse monitor (R8)
  logic prev_rv = 1'b0, prev_wd = 1'b0;
  always @(negedge clk) begin
    if (rvalid) n_rvalid++;
    if (wdone)  n_wdone++;
    if ((rvalid && prev_rv) || (wdone && prev_wd) || (rvalid && wdone)) begin
      n_chk++; n_fail++;
      $display("FAIL R8 pulse width actual=%b%b expected=single", rvalid, wdone);
    end
    prev_rv = rvalid;
    prev_wd = wdone;
  end

  // Watchdog
  always @(posedge clk) begin
    n_cyc++;
    if (n_cyc == 100000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected<100000", n_cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  function automatic int pins_vec();
    return int'({mem_en_n, mem_en, mem_rden_n, mem_wren_n, mem_dq_oe, busy, rvalid, wdone});
  endfunction

  task automatic do_op(input logic wr, input logic [12:0] a, input logic [7:0] d,
                       output int lat, output logic [7:0] rd);
    @(negedge clk);
    req = 1'b1; req_we = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    req = 1'b0;
    chk("R8", "busy after accept", int'(busy), 1);
    lat = 1;
    while (!(rvalid || wdone) && lat < 64) begin
      @(negedge clk);
      lat++;
    end
    chk("R8", "busy low at completion", int'(busy), 0);
    rd = rdata;
  endtask

  initial begin
    int lat, exp_lat, w0, r0;
    logic [7:0] rd, last_read;
    logic prev_rd, any_read;
    exp_rd   = imax(cyc_for(T_AA), cyc_for(T_DOE));
    exp_pwe  = imax(imax(cyc_for(T_PWE), cyc_for(T_AW)), cyc_for(T_SD));
    exp_wh   = imax(1, cyc_for(T_WC) - exp_pwe);
    exp_turn = cyc_for(T_HZOE);
    prev_rd = 1'b0; any_read = 1'b0; last_read = '0;

    repeat (3) @(negedge clk);
    chk("R1", "strobes in reset", pins_vec(), 8'hB0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "strobes after reset", pins_vec(), 8'hB0);

    // Vector table walk
    for (int i = 0; i < NVEC; i++) begin
      if (VECS[i].wr) exp_lat = 1 + exp_pwe + exp_wh + (prev_rd ? exp_turn : 0);
      else            exp_lat = 1 + exp_rd;
      do_op(VECS[i].wr, VECS[i].addr, VECS[i].data, lat, rd);
      if (VECS[i].wr) begin
        chk(prev_rd ? "R7" : "R5", "write latency (R10)", lat, exp_lat);
        chk("R5", "wdone at completion", int'(wdone), 1);
        if (any_read) chk("R6", "rdata held over write", int'(rdata), int'(last_read));
        prev_rd = 1'b0;
      end else begin
        chk("R6", "read latency (R10)", lat, exp_lat);
        chk("R6", "read data", int'(rd), int'(VECS[i].data));
        last_read = rd; any_read = 1'b1; prev_rd = 1'b1;
      end
    end
    @(negedge clk);
    chk("R8", "rvalid single cycle", int'(rvalid), 0);

    // Request while busy is ignored (R9)
    w0 = n_wdone; r0 = n_rvalid;
    @(negedge clk);
    req = 1'b1; req_we = 1'b1; req_addr = 13'h0777; req_wdata = 8'h99;
    @(negedge clk);
    req = 1'b1; req_we = 1'b1; req_addr = 13'h0888; req_wdata = 8'h11;
    chk("R9", "busy during write", int'(busy), 1);
    @(negedge clk);
    req = 1'b0;
    chk("R9", "address held while busy", int'(mem_addr), 13'h0777);
    repeat (8) @(negedge clk);
    chk("R9", "completions after busy request", n_wdone - w0 + n_rvalid - r0, 1);
    do_op(1'b0, 13'h0888, 8'h00, lat, rd);
    chk("R9", "ignored write left memory", int'(rd), 8'h00);
    do_op(1'b0, 13'h0777, 8'h00, lat, rd);
    chk("R9", "accepted write data", int'(rd), 8'h99);

    // Reset in the middle of a read (R1)
    @(negedge clk);
    req = 1'b1; req_we = 1'b0; req_addr = 13'h1FFF;
    @(negedge clk);
    req = 1'b0;
    chk("R6", "read strobe active", int'(mem_rden_n), 0);
    #1 rst_n = 1'b0;
    #1 chk("R1", "strobes after mid-read reset", pins_vec(), 8'hB0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "idle after reset release", pins_vec(), 8'hB0);
    do_op(1'b1, 13'h0042, 8'hE7, lat, rd);
    chk("R7", "write after reset has no turnaround", lat, 1 + exp_pwe + exp_wh);
    do_op(1'b0, 13'h0042, 8'h00, lat, rd);
    chk("R6", "read back after reset", int'(rd), 8'hE7);

    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule